// File: doc/BRIEF.md
# Synchronous Burst-Read Static Memory

This block is a clocked static memory that answers single reads, single-beat writes and four-beat burst reads. A master opens an access by pulsing an address strobe together with a start address, a burst request and a write enable. All inputs are sampled on the rising clock edge. Read data comes back on a registered output, qualified by a valid flag.

In a burst, the master drives the address only once. An internal counter then steps through the remaining words of the aligned four-word block that holds the start address. The master can hold off any beat after the first by dropping the advance input. While it is low the valid flag stays low. The held beat is delivered, with no data lost, on the next clock where advance is high. An uninterrupted burst follows a 2-1-1-1 pattern and finishes in five clocks. Four separate single reads would need eight.

Top module: `ssram_burst`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is 0 and `rd_data` is 0 until the first beat.
- R2: A strobe with `wr_en`=1 stores `wr_data` at `addr` on that edge and produces no beat; `rd_valid` stays low on the following cycles until a read is started.
- R3: A read strobe sampled at edge n gives `rd_valid`=0 after edge n. The first beat, the word at `addr`, appears after edge n+1 whatever the value of `adv`.
- R4: With `burst_en`=1, three more beats follow the first. Their addresses keep bits [ADDR_W-1:2] of the start address, and the low two bits count up by one modulo 4, so the burst wraps inside the aligned four-word block.
- R5: After the first beat, an edge with `adv`=0 delivers no beat: `rd_valid` is 0 and `rd_data` is unchanged. The pending beat is delivered, unchanged, at the next edge with `adv`=1.
- R6: With `burst_en`=0, a read produces exactly one beat.
- R7: After the last beat of an access, `rd_valid` stays 0 until a new read strobe.
- R8: A strobe while a burst is in progress abandons the remaining beats. The new access then proceeds as in R2 or R3.
- R9: An uninterrupted burst strobed at edge n places its four beats after edges n+1, n+2, n+3 and n+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Starts a new access at this edge |
| addr | input | ADDR_W | Start or write address, sampled with `strobe` |
| burst_en | input | 1 | 1 = four-beat burst read, 0 = single read |
| wr_en | input | 1 | 1 = the strobed access is a write |
| wr_data | input | DATA_W | Write data, sampled with `strobe` and `wr_en` |
| adv | input | 1 | 1 = advance the burst, 0 = suspend this clock |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High on exactly the cycles that a beat is presented |

## Verification
A read strobe sampled at one edge leaves the outputs idle for one cycle. The first beat is due one edge later, and each further beat is due one edge after the previous edge that had `adv` high. Writes produce no output at all. The bench drives inputs at the falling edge and samples outputs at the next falling edge, so each sample shows the result of exactly one rising edge. It walks the expected beat schedule cycle by cycle, computing each beat's address from the start address and the beats already taken. Random suspend masks, random aborts and a fixed-seed mix of writes and reads vary that schedule. A shadow memory supplies the expected data.

// File: rtl/ssram_burst.sv
module ssram_burst #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              adv,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BEATS = 4;
  localparam int CNT_W = $clog2(BEATS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  left;
  logic              busy, first;
  logic              fire;

  assign fire = busy && (first || adv);

  always_ff @(posedge clk)
    if (strobe && wr_en) mem[addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      first    <= 1'b0;
      left     <= '0;
      cur      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (strobe) begin
      rd_valid <= 1'b0;
      cur      <= addr;
      busy     <= !wr_en;
      first    <= 1'b1;
      left     <= burst_en ? CNT_W'(BEATS - 1) : '0;
    end else if (fire) begin
      rd_data  <= mem[cur];
      rd_valid <= 1'b1;
      cur      <= {cur[ADDR_W-1:CNT_W], cur[CNT_W-1:0] + 1'b1};
      first    <= 1'b0;
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end else begin
      rd_valid <= 1'b0;
    end
  end

  assert_idle_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !rd_valid);
  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wr_en) ##1 !strobe |=> rd_valid);
  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && wr_en) ##1 !strobe |=> !rd_valid);
  assert_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !first && !adv && !strobe |=> !rd_valid);
  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe && !fire |=> $stable(rd_data));
  assert_block_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !strobe |=> $stable(cur[ADDR_W-1:CNT_W]));
  assert_quiet_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !strobe |=> !rd_valid);
endmodule

// File: tb/ssram_burst_test.sv
module ssram_burst_test;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, burst_en = 0, wr_en = 0, adv = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  logic [DW-1:0] model [1<<AW];
  int checks = 0, fails = 0;
  bit done = 0;

  ssram_burst #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .burst_en(burst_en),
    .wr_en(wr_en), .wr_data(wr_data), .adv(adv), .rd_data(rd_data), .rd_valid(rd_valid));

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    strobe = 1; wr_en = 1; addr = a; wr_data = d; burst_en = 0;
    model[a] = d;
    @(negedge clk);
    strobe = 0; wr_en = 0;
    check(!rd_valid, "R2", rd_valid, 0);
  endtask

  // stop_after: number of beats after which the access is left (aborted); 0 = run to end
  task automatic do_read(logic [AW-1:0] a, bit burst, logic [7:0] susp, int stop_after);
    int total = burst ? 4 : 1;
    int got = 0;
    int cyc = 0;
    logic [DW-1:0] last;
    strobe = 1; wr_en = 0; addr = a; burst_en = burst;
    @(negedge clk);
    strobe = 0; adv = 0;
    check(!rd_valid, "R3", rd_valid, 0);
    @(negedge clk);
    check(rd_valid && rd_data == model[a], "R3", {15'(rd_valid), rd_data}, {15'(1), model[a]});
    got = 1; last = rd_data;
    while (got < total) begin
      if (stop_after != 0 && got >= stop_after) return;
      adv = !susp[cyc % 8];
      cyc++;
      @(negedge clk);
      if (adv) begin
        check(rd_valid && rd_data == model[beat_addr(a, got)], burst ? "R4" : "R6",
              {15'(rd_valid), rd_data}, {15'(1), model[beat_addr(a, got)]});
        got++; last = rd_data;
      end else begin
        check(!rd_valid && rd_data == last, "R5", {15'(rd_valid), rd_data}, {15'(0), last});
      end
    end
    adv = 1;
    @(negedge clk);
    check(!rd_valid, total == 1 ? "R6" : "R7", rd_valid, 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(!rd_valid && rd_data == 0, "R1", {15'(rd_valid), rd_data}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!rd_valid && rd_data == 0, "R1", {15'(rd_valid), rd_data}, 0);

    for (int i = 0; i < (1 << AW); i++) do_write(AW'(i), DW'($urandom));
    @(negedge clk);
    check(!rd_valid, "R2", rd_valid, 0);

    // R9: uninterrupted 2-1-1-1 burst
    do_read(8'h10, 1, 8'h00, 0);
    // R4 wrap from offset 2 and 3
    do_read(8'h22, 1, 8'h00, 0);
    do_read(8'h37, 1, 8'h00, 0);
    // R6 single read, adv held low for first beat
    do_read(8'h45, 0, 8'h00, 0);
    // R5 suspends between beats, including two in a row
    do_read(8'h51, 1, 8'b0000_1101, 0);
    // R8 abort after two beats, then new burst
    do_read(8'h60, 1, 8'h00, 2);
    do_read(8'h83, 1, 8'h00, 0);
    // R8 abort by a write
    do_read(8'h90, 1, 8'h00, 1);
    do_write(8'h91, 16'hBEEF);
    @(negedge clk);
    check(!rd_valid, "R8", rd_valid, 0);
    do_read(8'h90, 1, 8'h00, 0);

    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 3);
      logic [AW-1:0] a = AW'($urandom);
      if (op == 0) do_write(a, DW'($urandom));
      else do_read(a, op != 1, 8'($urandom) & 8'h55, (op == 3) ? $urandom_range(1, 3) : 0);
    end
    adv = 1;
    repeat (2) @(negedge clk);
    check(!rd_valid, "R7", rd_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule